// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation structure that lives in ordinary memory. A directory base input gives the page-aligned location of the first-level table. The walker takes one request, with an access type (read or write) and a privilege (user or supervisor). It then fetches the directory entry over a single-word memory port and, if needed, the second-level entry. It checks the presence and permission bits of each entry it fetches. The walk ends in one of two ways: a done pulse with the physical address, or a fault pulse with a three-bit error code.

A directory entry can also map a 4MB region directly, and then the walk stops after one read. Each entry that a walk uses has its accessed flag set in memory. A successful write also sets the dirty flag of the last entry used. The walker writes an entry back only when one of these flags actually changes. The memory port has no fixed latency. The walker holds each request, with its address and data, until the memory answers it.

Top module: `pgw_top`

## Requirements
- R1: The directory entry is read at `{dir_base[31:12],12'h000} + 4*va[31:22]`. The second-level entry is read at `{pde[31:12],12'h000} + 4*va[21:12]`. A 4KB result is `{pte[31:12], va[11:0]}`.
- R2: If an entry with bit 0 (present) clear is read at either level, the walk ends in a fault with code bit 0 = 0.
- R3: A present directory entry with bit 7 set maps a 4MB page. The result is `{pde[31:22], va[21:0]}` and no second-level read is made.
- R4: A user access (`req_user`=1) needs bit 2 set in every entry the walk uses. Otherwise the walk faults with code bit 0 = 1.
- R5: A user write needs bit 1 set in every entry the walk uses. Otherwise the walk faults with code bit 0 = 1.
- R6: For a supervisor access, bit 1 has no effect: a supervisor write to a read-only mapping completes.
- R7: Bit 5 (accessed) is set in memory on every entry the walk passes successfully. Bit 6 (dirty) is set on the last entry of a successful write. An entry is written back only if its value changes. Every write carries bit 5 set.
- R8: Fault code bit 1 equals the write flag of the request, and bit 2 equals its user flag.
- R9: `busy` is high from the cycle after a request is accepted until the cycle in which `done` or `fault` pulses. While `busy` is high, `req_valid` is ignored.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R11: `done` and `fault` are one-cycle pulses and are never high together. `mem_req` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 32 | Page-aligned physical address of the directory |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| paddr | output | 32 | Physical address, valid with done |
| fault_code | output | 3 | {user, write, protection}, valid with fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Memory has completed the pending access |
| mem_rdata | input | 32 | Read data, valid with mem_ack on a read |

## Verification
The assertions check the memory handshake on every cycle: requests stay stable while the memory stalls, no request is made outside a walk, and no write-back leaves the accessed flag clear. They also check that done, fault and busy agree with each other. Only the bench scenarios can show whether a given address, permission combination or large-page entry gives the right physical address or fault code. The same applies to which entries end up updated in memory and how many write-backs a walk makes. These are checked against a behavioural model at memory latencies of zero to several cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DIR,
    S_WB_DIR,
    S_RD_TBL,
    S_WB_TBL
  } walk_st_t;

  localparam int unsigned B_PRES  = 0;
  localparam int unsigned B_WRITE = 1;
  localparam int unsigned B_USER  = 2;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_DIRTY = 6;
  localparam int unsigned B_LARGE = 7;
endpackage

// File: rtl/pgw_check.sv
// Entry checker: presence, privilege and write permission, plus flag update.
module pgw_check
  import pgw_pkg::*;
#(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] entry,
  input  logic          is_final,
  input  logic          acc_wr,
  input  logic          acc_usr,
  output logic          pass,
  output logic          prot,
  output logic [EW-1:0] upd_entry,
  output logic          need_wb
);
  logic present;
  logic perm_ok;

  always_comb begin
    present   = entry[B_PRES];
    // a supervisor access ignores the write bit
    perm_ok   = (!acc_usr || entry[B_USER]) &&
                (!(acc_usr && acc_wr) || entry[B_WRITE]);
    pass      = present && perm_ok;
    prot      = present && !perm_ok;
    upd_entry = entry;
    upd_entry[B_ACC] = 1'b1;
    if (is_final && acc_wr) upd_entry[B_DIRTY] = 1'b1;
    need_wb   = (upd_entry != entry);
  end
endmodule

// File: rtl/pgw_walk.sv
// Walk sequencer: memory port, state, registered results.
module pgw_walk
  import pgw_pkg::*;
#(
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] dir_base,
  input  logic             req_valid,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [DIR_W+TBL_W+OFF_W-1:0] paddr,
  output logic [2:0]       fault_code,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_addr,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] mem_rdata,
  output logic             chk_final,
  output logic             chk_wr,
  output logic             chk_usr,
  input  logic             chk_pass,
  input  logic             chk_prot,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] chk_upd,
  input  logic             chk_wb
);
  localparam int unsigned AW    = DIR_W + TBL_W + OFF_W;
  localparam int unsigned LG_LO = OFF_W + TBL_W;

  walk_st_t        st;
  logic [AW-1:0]   va_q;
  logic            wr_q;
  logic            usr_q;
  logic            lg_q;
  logic [AW-1:0]   ent_q;

  function automatic logic [AW-1:0] dir_addr(input logic [AW-1:0] base,
                                             input logic [AW-1:0] va);
    return {base[AW-1:OFF_W], {OFF_W{1'b0}}} |
           AW'({va[AW-1 -: DIR_W], 2'b00});
  endfunction

  function automatic logic [AW-1:0] tbl_addr(input logic [AW-1:0] e,
                                             input logic [AW-1:0] va);
    return {e[AW-1:OFF_W], {OFF_W{1'b0}}} |
           AW'({va[LG_LO-1 -: TBL_W], 2'b00});
  endfunction

  assign chk_final = (st == S_RD_TBL) || mem_rdata[B_LARGE];
  assign chk_wr    = wr_q;
  assign chk_usr   = usr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      lg_q       <= 1'b0;
      ent_q      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      paddr      <= '0;
      fault_code <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            usr_q    <= req_user;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_addr(dir_base, req_vaddr);
            st       <= S_RD_DIR;
          end
        end
        S_RD_DIR: begin
          if (mem_ack) begin
            if (!chk_pass) begin
              fault      <= 1'b1;
              fault_code <= {usr_q, wr_q, chk_prot};
              busy       <= 1'b0;
              mem_req    <= 1'b0;
              st         <= S_IDLE;
            end else begin
              ent_q <= chk_upd;
              lg_q  <= mem_rdata[B_LARGE];
              if (chk_wb) begin
                mem_we    <= 1'b1;
                mem_wdata <= chk_upd;
                st        <= S_WB_DIR;
              end else if (mem_rdata[B_LARGE]) begin
                done    <= 1'b1;
                paddr   <= {mem_rdata[AW-1:LG_LO], va_q[LG_LO-1:0]};
                busy    <= 1'b0;
                mem_req <= 1'b0;
                st      <= S_IDLE;
              end else begin
                mem_addr <= tbl_addr(mem_rdata, va_q);
                st       <= S_RD_TBL;
              end
            end
          end
        end
        S_WB_DIR: begin
          if (mem_ack) begin
            mem_we <= 1'b0;
            if (lg_q) begin
              done    <= 1'b1;
              paddr   <= {ent_q[AW-1:LG_LO], va_q[LG_LO-1:0]};
              busy    <= 1'b0;
              mem_req <= 1'b0;
              st      <= S_IDLE;
            end else begin
              mem_addr <= tbl_addr(ent_q, va_q);
              st       <= S_RD_TBL;
            end
          end
        end
        S_RD_TBL: begin
          if (mem_ack) begin
            if (!chk_pass) begin
              fault      <= 1'b1;
              fault_code <= {usr_q, wr_q, chk_prot};
              busy       <= 1'b0;
              mem_req    <= 1'b0;
              st         <= S_IDLE;
            end else if (chk_wb) begin
              ent_q     <= chk_upd;
              mem_we    <= 1'b1;
              mem_wdata <= chk_upd;
              st        <= S_WB_TBL;
            end else begin
              done    <= 1'b1;
              paddr   <= {mem_rdata[AW-1:OFF_W], va_q[OFF_W-1:0]};
              busy    <= 1'b0;
              mem_req <= 1'b0;
              st      <= S_IDLE;
            end
          end
        end
        S_WB_TBL: begin
          if (mem_ack) begin
            done    <= 1'b1;
            paddr   <= {ent_q[AW-1:OFF_W], va_q[OFF_W-1:0]};
            busy    <= 1'b0;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));
  // R11
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  // R11
  req_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R9
  idle_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> !busy);
  // R7
  wb_sets_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[B_ACC]);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] dir_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [31:0] paddr,
  output logic [2:0]  fault_code,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int unsigned AW = DIR_W + TBL_W + OFF_W;

  logic          chk_final;
  logic          chk_wr;
  logic          chk_usr;
  logic          chk_pass;
  logic          chk_prot;
  logic [AW-1:0] chk_upd;
  logic          chk_wb;

  pgw_check #(.EW(AW)) u_check (
    .entry     (mem_rdata),
    .is_final  (chk_final),
    .acc_wr    (chk_wr),
    .acc_usr   (chk_usr),
    .pass      (chk_pass),
    .prot      (chk_prot),
    .upd_entry (chk_upd),
    .need_wb   (chk_wb)
  );

  pgw_walk #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .dir_base   (dir_base),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_user   (req_user),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .paddr      (paddr),
    .fault_code (fault_code),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .chk_final  (chk_final),
    .chk_wr     (chk_wr),
    .chk_usr    (chk_usr),
    .chk_pass   (chk_pass),
    .chk_prot   (chk_prot),
    .chk_upd    (chk_upd),
    .chk_wb     (chk_wb)
  );
endmodule

// File: tb/pgw_top_bench.sv
module pgw_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dir_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy, done, fault;
  logic [31:0] paddr;
  logic [2:0]  fault_code;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int lat = 0;
  int wcnt = 0;
  int wr_count = 0;
  bit exp_busy = 1'b0;
  logic [31:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  pgw_top u_pgw_top (
    .clk(clk), .rst(rst), .dir_base(dir_base), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .done(done), .fault(fault), .paddr(paddr),
    .fault_code(fault_code), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory with programmable wait states
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = lat;
    end else if (mem_req && !rst) begin
      if (wcnt <= 0) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_count++;
        end else begin
          mem_rdata = rd(mem_addr);
        end
        mem_ack = 1'b1;
      end else begin
        wcnt--;
      end
    end
  end

  // per-cycle busy reference (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (done || fault) exp_busy = 1'b0;
      check(busy == exp_busy, "R9", "busy per cycle", {31'b0, busy}, {31'b0, exp_busy});
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // behavioural reference for one walk
  task automatic model(input logic [31:0] va, input bit wr, input bit usr,
                       output bit f, output logic [2:0] code,
                       output logic [31:0] pa, output int nw,
                       output logic [31:0] da, output logic [31:0] dv,
                       output logic [31:0] ta, output logic [31:0] tv);
    logic [31:0] d, t;
    nw = 0; ta = 0; tv = 0; pa = 0; code = 0; f = 1'b1;
    da = {dir_base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
    d  = rd(da);
    dv = d;
    if (!d[0]) begin code = {usr, wr, 1'b0}; return; end
    if ((usr && !d[2]) || (usr && wr && !d[1])) begin code = {usr, wr, 1'b1}; return; end
    if (d[7]) begin
      dv = d | 32'h20 | (wr ? 32'h40 : 32'h0);
      nw = (dv != d) ? 1 : 0;
      f  = 1'b0;
      pa = {d[31:22], va[21:0]};
      return;
    end
    dv = d | 32'h20;
    nw = (dv != d) ? 1 : 0;
    ta = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    t  = rd(ta);
    tv = t;
    if (!t[0]) begin code = {usr, wr, 1'b0}; return; end
    if ((usr && !t[2]) || (usr && wr && !t[1])) begin code = {usr, wr, 1'b1}; return; end
    tv = t | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (tv != t) nw++;
    f  = 1'b0;
    pa = {t[31:12], va[11:0]};
  endtask

  task automatic walk(input string req, input logic [31:0] va, input bit wr,
                      input bit usr, input int latency, input bit poke);
    bit f; logic [2:0] code; logic [31:0] pa, da, dv, ta, tv; int nw;
    int guard;
    model(va, wr, usr, f, code, pa, nw, da, dv, ta, tv);
    lat = latency;
    wcnt = latency;
    wr_count = 0;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(posedge clk);
    exp_busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // a second request during the walk must be dropped (R9)
      req_vaddr = va ^ 32'h0040_0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!(done || fault) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(fault == f, req, "outcome fault", {31'b0, fault}, {31'b0, f});
    if (f) check(fault_code == code, {req, "/R8"}, "fault code", {29'b0, fault_code}, {29'b0, code});
    else   check(paddr == pa, req, "physical address", paddr, pa);
    @(negedge clk);
    check(!done && !fault, "R11", "single pulse", {30'b0, done, fault}, 32'h0);
    repeat (3) @(negedge clk);
    check(wr_count == nw, {req, "/R7"}, "write-back count", wr_count, nw);
    check(rd(da) == dv, {req, "/R7"}, "directory entry", rd(da), dv);
    if (ta != 0) check(rd(ta) == tv, {req, "/R7"}, "table entry", rd(ta), tv);
  endtask

  initial begin
    // directory at 0x0010_0000, table at 0x0020_0000
    mem[32'h0010_0004] = 32'h0020_0007;   // idx1: P RW U -> table
    mem[32'h0020_0014] = 32'h0ABC_D007;   // idx5: P RW U
    mem[32'h0020_0018] = 32'h0BBB_B001;   // idx6: P, read-only, supervisor
    mem[32'h0020_001C] = 32'h0CCC_C004;   // idx7: not present
    mem[32'h0010_0008] = 32'h0020_0001;   // idx2: P, supervisor, read-only
    mem[32'h0010_000C] = 32'h1AC0_0087;   // idx3: large P RW U
    mem[32'h0010_0010] = 32'h0020_0005;   // idx4: P U, read-only dir
    // idx0 absent -> not present

    repeat (3) @(negedge clk);
    check(!busy && !done && !fault && !mem_req, "R9", "reset state",
          {28'b0, busy, done, fault, mem_req}, 32'h0);
    rst = 1'b0;

    walk("R1", 32'h0040_5123, 1'b0, 1'b0, 0, 1'b0);   // 4KB read, sets both A
    walk("R1", 32'h0040_5FFC, 1'b0, 1'b1, 3, 1'b0);   // repeat, no write-back
    walk("R6", 32'h0040_6010, 1'b1, 1'b0, 1, 1'b0);   // sup write to RO page
    walk("R4", 32'h0080_5000, 1'b0, 1'b1, 2, 1'b0);   // user, dir supervisor
    walk("R2", 32'h0000_1000, 1'b1, 1'b0, 0, 1'b0);   // dir not present
    walk("R2", 32'h0040_7000, 1'b0, 1'b1, 4, 1'b0);   // table not present
    walk("R3", 32'h00C1_2345, 1'b0, 1'b0, 2, 1'b0);   // large read
    walk("R3", 32'h00FF_FFFF, 1'b1, 1'b1, 0, 1'b0);   // large user write, dirty
    walk("R5", 32'h0100_5000, 1'b1, 1'b1, 1, 1'b0);   // dir read-only, user write
    walk("R5", 32'h0040_6000, 1'b1, 1'b1, 2, 1'b0);   // table RO + supervisor
    walk("R4", 32'h0100_5000, 1'b0, 1'b1, 3, 1'b0);   // user read via RO dir ok
    walk("R9", 32'h0040_5004, 1'b1, 1'b1, 5, 1'b1);   // ignored second request
    walk("R10", 32'h0040_5008, 1'b1, 1'b0, 7, 1'b0);  // long stalls

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule